// File: doc/BRIEF.md
# Per-CPU Interrupt Claim and Completion Interface

This block is the processor-facing side of an interrupt controller for one CPU. Software steers it with command writes that carry an interrupt number. One command unmasks that interrupt, one masks it and one declares its service finished. A single read-only identifier register tells the CPU which interrupt to handle next. A gate bit in a control register switches the whole interface on or off.

Internally the block holds one enable bit and one in-service (active) bit per interrupt. Pending flags arrive from an external trigger detector. An interrupt is a candidate when it is pending, enabled and not active. The lowest-numbered candidate is the one reported. Reading the identifier claims that interrupt: it becomes active and drops out of the candidate set until software completes it. The request line to the CPU is high while the gate is on and at least one candidate exists.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset the request output is 0, the control register reads 0 and every enable and active bit is clear. A pending input therefore causes no request, even once the gate is opened.
- R2: Bit 0 of the control register (offset 0x00) gates the interface and reads back as written. While it is 0, the request output is 0 and the identifier read returns all ones, whatever is pending. Enable, mask and completion commands still take effect.
- R3: Writing an interrupt number N to offset 0xA0 sets the enable bit of interrupt N.
- R4: Writing N to offset 0xA4 clears the enable bit of interrupt N, and N is no longer reported.
- R5: When several candidates exist, a read of offset 0x6C returns the lowest-numbered one, zero-extended to the data width.
- R6: A read of the identifier that returns N marks N active. From the next cycle, N is excluded from the candidates. The request output falls if no other candidate remains.
- R7: An identifier read with no candidate, or with the gate closed, returns all ones (0xFFFFFFFF at the default width) and changes no state.
- R8: Writing N to offset 0xB4 while N is active clears its active bit. N is then reported again if it is still pending and enabled.
- R9: A completion write for an interrupt that is not active changes no active bit.
- R10: A command whose data value is NUM_IRQ or larger is ignored. It is not truncated onto a lower interrupt number.
- R11: The request output follows the pending inputs in the same cycle, with no register between them. When the last candidate's pending flag drops, the request falls at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | DATA_W | Write data (interrupt number for commands) |
| rdata | output | DATA_W | Read data, valid the cycle after rd_en |
| pend_i | input | NUM_IRQ | Pending flags from the trigger detector |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
A stuck or wrong active bit shows up at the next identifier read. The read either skips an interrupt that should be claimable or repeats one that was already claimed. A lost enable bit, or one written to the wrong number, shows up as a missing or extra request in the cycle after the command. A wrong priority order appears in the very first read that follows a multi-interrupt pending pattern. Out-of-range and ignored commands are exposed by the request line and the identifier read in the cycles that follow them.

// File: rtl/cpu_irq_pkg.sv
package cpu_irq_pkg;

  localparam int unsigned OFS_CTRL  = 32'h00;
  localparam int unsigned OFS_ID    = 32'h6C;
  localparam int unsigned OFS_SETEN = 32'hA0;
  localparam int unsigned OFS_CLREN = 32'hA4;
  localparam int unsigned OFS_DONE  = 32'hB4;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_SET_EN = 2'd1,
    CMD_CLR_EN = 2'd2,
    CMD_DONE   = 2'd3
  } cmd_kind_e;

  // A command number is usable only when it names an existing interrupt.
  function automatic logic id_in_range(input logic [31:0] value, input int unsigned count);
    return value < count;
  endfunction

endpackage

// File: rtl/cpu_irq_decode.sv
module cpu_irq_decode
  import cpu_irq_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDW    = $clog2(NUM_IRQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ready,
  input  logic [IDW-1:0]    best_id,
  output logic              iface_en,
  output cmd_kind_e         cmd_kind,
  output logic              cmd_ok,
  output logic [IDW-1:0]    cmd_id,
  output logic              claim_fire,
  output logic [DATA_W-1:0] rdata
);

  logic gate_q;
  logic [DATA_W-1:0] rdata_q;
  logic id_read;

  assign id_read = rd_en && (addr == ADDR_W'(OFS_ID));

  always_comb begin
    cmd_kind = CMD_NONE;
    if (wr_en) begin
      if (addr == ADDR_W'(OFS_SETEN))      cmd_kind = CMD_SET_EN;
      else if (addr == ADDR_W'(OFS_CLREN)) cmd_kind = CMD_CLR_EN;
      else if (addr == ADDR_W'(OFS_DONE))  cmd_kind = CMD_DONE;
    end
  end

  assign cmd_ok     = (cmd_kind != CMD_NONE) && id_in_range(32'(wdata), NUM_IRQ);
  assign cmd_id     = wdata[IDW-1:0];
  assign claim_fire = id_read && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
    end else if (wr_en && (addr == ADDR_W'(OFS_CTRL))) begin
      gate_q <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      if (addr == ADDR_W'(OFS_CTRL))    rdata_q <= DATA_W'(gate_q);
      else if (addr == ADDR_W'(OFS_ID)) rdata_q <= ready ? DATA_W'(best_id) : '1;
      else                              rdata_q <= '0;
    end
  end

  assign iface_en = gate_q;
  assign rdata    = rdata_q;

  AST_EMPTY_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (id_read && !ready) |=> (rdata == {DATA_W{1'b1}})); // R7

endmodule

// File: rtl/cpu_irq_state.sv
module cpu_irq_state
  import cpu_irq_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32,
  localparam int unsigned IDW    = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  cmd_kind_e          cmd_kind,
  input  logic               cmd_ok,
  input  logic [IDW-1:0]     cmd_id,
  input  logic               claim_fire,
  input  logic [IDW-1:0]     claim_id,
  output logic [NUM_IRQ-1:0] en_q,
  output logic [NUM_IRQ-1:0] act_q
);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    logic en_r;
    logic act_r;
    logic hit;

    assign hit = cmd_ok && (cmd_id == IDW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_r <= 1'b0;
      end else if (hit && (cmd_kind == CMD_SET_EN)) begin
        en_r <= 1'b1;
      end else if (hit && (cmd_kind == CMD_CLR_EN)) begin
        en_r <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_r <= 1'b0;
      end else if (claim_fire && (claim_id == IDW'(i))) begin
        act_r <= 1'b1;
      end else if (hit && (cmd_kind == CMD_DONE)) begin
        act_r <= 1'b0;
      end
    end

    assign en_q[i]  = en_r;
    assign act_q[i] = act_r;
  end

  AST_CLAIM_MARKS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    claim_fire |=> act_q[$past(claim_id)]); // R6

  AST_SET_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && (cmd_kind == CMD_SET_EN)) |=> en_q[$past(cmd_id)]); // R3

  AST_DONE_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && (cmd_kind == CMD_DONE) && !act_q[cmd_id] && !claim_fire)
      |=> $stable(act_q)); // R9

endmodule

// File: rtl/cpu_irq_pick.sv
module cpu_irq_pick #(
  parameter int unsigned NUM_IRQ = 32,
  localparam int unsigned IDW    = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] pend,
  input  logic [NUM_IRQ-1:0] en,
  input  logic [NUM_IRQ-1:0] act,
  output logic               has_cand,
  output logic [IDW-1:0]     best_id
);

  logic [NUM_IRQ-1:0] cand;

  assign cand     = pend & en & ~act;
  assign has_cand = |cand;

  always_comb begin
    best_id = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (cand[i]) best_id = IDW'(i);
    end
  end

  AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    has_cand |-> (cand[best_id] &&
      ((cand & ((NUM_IRQ'(1) << best_id) - NUM_IRQ'(1))) == '0))); // R5

endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface
  import cpu_irq_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDW    = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NUM_IRQ-1:0] pend_i,
  output logic               irq_o
);

  logic               iface_en;
  cmd_kind_e          cmd_kind;
  logic               cmd_ok;
  logic [IDW-1:0]     cmd_id;
  logic               claim_fire;
  logic [NUM_IRQ-1:0] en_q;
  logic [NUM_IRQ-1:0] act_q;
  logic               has_cand;
  logic [IDW-1:0]     best_id;
  logic               ready;

  assign ready = iface_en && has_cand;
  assign irq_o = ready;

  cpu_irq_decode #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .ready(ready), .best_id(best_id), .iface_en(iface_en),
    .cmd_kind(cmd_kind), .cmd_ok(cmd_ok), .cmd_id(cmd_id),
    .claim_fire(claim_fire), .rdata(rdata)
  );

  cpu_irq_state #(.NUM_IRQ(NUM_IRQ)) u_state (
    .clk(clk), .rst_n(rst_n), .cmd_kind(cmd_kind), .cmd_ok(cmd_ok),
    .cmd_id(cmd_id), .claim_fire(claim_fire), .claim_id(best_id),
    .en_q(en_q), .act_q(act_q)
  );

  cpu_irq_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
    .clk(clk), .rst_n(rst_n), .pend(pend_i), .en(en_q), .act(act_q),
    .has_cand(has_cand), .best_id(best_id)
  );

  AST_GATE_CLOSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!iface_en && rd_en && (addr == ADDR_W'(OFS_ID))) |=> (rdata == {DATA_W{1'b1}})); // R2

endmodule

// File: tb/cpu_irq_iface_bench.sv
module cpu_irq_iface_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;
  localparam logic [31:0] NONE = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] pend = '0;
  logic irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_irq_iface u_cpu_irq_iface (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pend_i(pend), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq after reset", 32'(irq), 0);
    rd(8'h00, v); chk("R1 ctrl after reset", v, 0);
    pend = '1;
    rd(8'h6C, v); chk("R1 id with gate closed", v, NONE);
    wr(8'h00, 1);
    chk("R1 no enables no request", 32'(irq), 0);
    rd(8'h6C, v); chk("R1 id with no enables", v, NONE);
    rd(8'h00, v); chk("R2 ctrl readback", v, 1);
    pend = '0;
  endtask

  task automatic t_gate();
    logic [31:0] v;
    @(negedge clk); pend = 32'h0000_0010;
    wr(8'hA0, 4);
    chk("R3 enable raises request", 32'(irq), 1);
    wr(8'h00, 0);
    chk("R2 gate closed drops request", 32'(irq), 0);
    rd(8'h6C, v); chk("R2 gate closed id", v, NONE);
    wr(8'h00, 1);
    chk("R2 gate reopened", 32'(irq), 1);
  endtask

  task automatic t_lowest();
    logic [31:0] v;
    @(negedge clk); pend = 32'h0010_0210;
    wr(8'hA0, 20); wr(8'hA0, 9);
    rd(8'h6C, v); chk("R5 lowest first", v, 4);
    chk("R6 request stays with others", 32'(irq), 1);
    rd(8'h6C, v); chk("R5 next lowest", v, 9);
    rd(8'h6C, v); chk("R5 last", v, 20);
    chk("R6 request drops all claimed", 32'(irq), 0);
    rd(8'h6C, v); chk("R7 empty id", v, NONE);
  endtask

  task automatic t_complete();
    logic [31:0] v;
    wr(8'hB4, 5);
    chk("R9 idle completion no request", 32'(irq), 0);
    rd(8'h6C, v); chk("R9 idle completion id", v, NONE);
    wr(8'hB4, 9);
    chk("R8 completion re-raises", 32'(irq), 1);
    rd(8'h6C, v); chk("R8 reclaim", v, 9);
    wr(8'hB4, 4); wr(8'hB4, 9); wr(8'hB4, 20);
    wr(8'hA4, 4);
    rd(8'h6C, v); chk("R4 masked skipped", v, 9);
    wr(8'hB4, 9);
    wr(8'hA4, 9); wr(8'hA4, 20);
    chk("R4 all masked", 32'(irq), 0);
  endtask

  task automatic t_range();
    logic [31:0] v;
    @(negedge clk); pend = 32'h0000_0080;
    wr(8'hA0, N + 7);
    chk("R10 out-of-range enable", 32'(irq), 0);
    @(negedge clk); pend = 32'h0010_0080;
    wr(8'hA0, 20);
    wr(8'hA4, N + 20);
    chk("R10 out-of-range mask", 32'(irq), 1);
    rd(8'h6C, v); chk("R10 id after ignored mask", v, 20);
    wr(8'hB4, N + 20);
    rd(8'h6C, v); chk("R10 out-of-range completion", v, NONE);
    wr(8'hB4, 20); wr(8'hA4, 20);
  endtask

  task automatic t_pend_drop();
    logic [31:0] v;
    @(negedge clk); pend = 32'h0000_1000;
    wr(8'hA0, 12);
    chk("R11 request with pending", 32'(irq), 1);
    @(negedge clk); pend = '0; #1;
    chk("R11 request same cycle drop", 32'(irq), 0);
    rd(8'h6C, v); chk("R11 id after drop", v, NONE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gate();
    t_lowest();
    t_complete();
    t_range();
    t_pend_drop();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule